// File: doc/BRIEF.md
# I2C Byte-Register Target

This block is an I2C target that answers to one fixed 7-bit device address. It gives an external host byte-wide access to a register space inside the chip. The block has an internal register pointer. In a write transfer, the first byte after the address loads the pointer. Every byte after that is written at the pointer, and the pointer then steps on by one. A read transfer returns bytes from the current pointer, and the pointer steps after each byte it fetches. A host can write the pointer, issue a repeated start and then read from that pointer in one transfer.

SCL and SDA are sampled by the faster system clock through multi-flop synchronizers. Start, stop and bit edges are found in the system clock domain. The register side is a plain byte bus: pointer address, write data, a one-cycle write strobe, a one-cycle read strobe and read data. The target never stretches SCL. It drives SDA only as an open-drain pull-down.

Top module: `i2c_regport`

## Requirements
- R1: After a start, the target acknowledges an address byte whose upper seven bits are 0101010. It acknowledges by pulling SDA low during the ninth SCL pulse. Bit 0 of that byte selects write (0) or read (1).
- R2: An address byte that does not match gets no acknowledge. It also causes no write or read strobe. Every later byte is ignored until the next start condition.
- R3: In a write transfer, the first byte after the address loads the register pointer, and that byte is acknowledged.
- R4: Each further byte of a write transfer is acknowledged. It produces a one-cycle `reg_we` with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The pointer increments on the following cycle.
- R5: A read transfer returns bytes MSB first, starting at the current pointer. Each byte is fetched with a one-cycle `reg_re`, and `reg_rdata` is sampled on the cycle after `reg_re`. The pointer increments once per byte fetched.
- R6: A host acknowledge after a read byte makes the target fetch and send the next byte. A host not-acknowledge makes the target release SDA and fetch nothing more.
- R7: A repeated start after the pointer byte, followed by the address with the read bit, starts the read at the newly loaded pointer.
- R8: A start or stop condition in the middle of a byte abandons that byte. No strobe is issued, the pointer keeps its value, and bit counting restarts.
- R9: The pointer is 8 bits wide and wraps from 0xFF to 0x00, for both writes and reads.
- R10: After reset, SDA is released, both strobes are low and the pointer is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_addr | output | PTR_W (8) | Register pointer used as the bus address |
| reg_wdata | output | 8 | Byte to be written |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read byte, valid on the cycle after `reg_re` |

## Verification
The hardest case to reach from the ports is a start or stop condition that lands partway through a byte. To reach it, the bench's bit-level master tasks shift out only three or four bits of a pointer or data byte, then create the bus condition directly. The bench then shows through a plain read that the pointer did not move. A full 256-byte burst write followed by a 256-byte combined read takes the pointer through its wrap twice. A sweep over all 128 addresses shows that only one of them is acknowledged.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_PTR,
      ST_PTR_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_TX,
      ST_HOST_ACK
   } tgt_state_t;

   localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/i2c_regport_sync.sv
module i2c_regport_sync #(
   parameter int unsigned LINES  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] line_i,
   output logic [LINES-1:0] level_o,
   output logic [LINES-1:0] rise_o,
   output logic [LINES-1:0] fall_o
);

   logic [LINES-1:0] chain [STAGES];
   logic [LINES-1:0] prev_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_regport_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= '1;
               else        chain[0] <= line_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '1;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '1;
      else        prev_q <= chain[STAGES-1];
   end

   assign level_o = chain[STAGES-1];
   assign rise_o  = chain[STAGES-1] & ~prev_q;
   assign fall_o  = ~chain[STAGES-1] & prev_q;

endmodule

// File: rtl/i2c_regport_ptr.sv
module i2c_regport_ptr #(
   parameter int unsigned PTR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [PTR_W-1:0] din,
   input  logic             inc,
   output logic [PTR_W-1:0] ptr
);

   localparam logic [PTR_W-1:0] ONE = {{(PTR_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr <= '0;
      else if (load) ptr <= din;
      else if (inc)  ptr <= ptr + ONE;
   end

endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
   import i2c_regport_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR    = 7'b0101010,
   parameter int unsigned PTR_W       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe,
   output logic [PTR_W-1:0] reg_addr,
   output logic [7:0]       reg_wdata,
   output logic             reg_we,
   output logic             reg_re,
   input  logic [7:0]       reg_rdata
);

   localparam int unsigned CNT_W = 4;
   localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

   generate
      if (PTR_W < 1 || PTR_W > BYTE_W) begin : g_bad_ptr
         $error("i2c_regport: PTR_W must be within 1..8");
      end
   endgenerate

   // line conditioning: index 0 = SCL, index 1 = SDA
   logic [1:0] lvl, rise, fall;

   i2c_regport_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i ({sda_i, scl_i}),
      .level_o(lvl),
      .rise_o (rise),
      .fall_o (fall)
   );

   logic scl_s, sda_s, scl_up, scl_dn, bus_start, bus_stop;
   assign scl_s     = lvl[0];
   assign sda_s     = lvl[1];
   assign scl_up    = rise[0];
   assign scl_dn    = fall[0];
   assign bus_start = scl_s & fall[1];
   assign bus_stop  = scl_s & rise[1];

   tgt_state_t       state;
   logic [7:0]       rx_sh, tx_sh, rbuf;
   logic [CNT_W-1:0] bcnt;
   logic [2:0]       tcnt;
   logic             is_read, next_pend, re_q;
   logic             ptr_load, ptr_inc;
   logic [PTR_W-1:0] ptr_din, ptr;

   i2c_regport_ptr #(.PTR_W(PTR_W)) u_ptr (
      .clk  (clk),
      .rst_n(rst_n),
      .load (ptr_load),
      .din  (ptr_din),
      .inc  (ptr_inc),
      .ptr  (ptr)
   );

   assign reg_addr = ptr;

   // read data capture, one cycle after the strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         re_q <= 1'b0;
         rbuf <= '0;
      end else begin
         re_q <= reg_re;
         if (re_q) rbuf <= reg_rdata;
      end
   end

   // receive shifter, active in the byte-collecting states
   logic rx_state;
   assign rx_state = (state == ST_ADDR) || (state == ST_PTR) || (state == ST_WR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         rx_sh     <= '0;
         tx_sh     <= '0;
         bcnt      <= '0;
         tcnt      <= '0;
         is_read   <= 1'b0;
         next_pend <= 1'b0;
         sda_oe    <= 1'b0;
         reg_we    <= 1'b0;
         reg_re    <= 1'b0;
         reg_wdata <= '0;
         ptr_load  <= 1'b0;
         ptr_inc   <= 1'b0;
         ptr_din   <= '0;
      end else begin
         reg_we   <= 1'b0;
         reg_re   <= 1'b0;
         ptr_load <= 1'b0;
         ptr_inc  <= 1'b0;
         if (bus_start) begin
            state     <= ST_ADDR;
            bcnt      <= '0;
            next_pend <= 1'b0;
            sda_oe    <= 1'b0;
         end else if (bus_stop) begin
            state     <= ST_IDLE;
            bcnt      <= '0;
            next_pend <= 1'b0;
            sda_oe    <= 1'b0;
         end else if (rx_state && scl_up && bcnt != FULL) begin
            rx_sh <= {rx_sh[6:0], sda_s};
            bcnt  <= bcnt + 1'b1;
         end else if (scl_dn) begin
            unique case (state)
               ST_ADDR: if (bcnt == FULL) begin
                  if (rx_sh[7:1] == DEV_ADDR) begin
                     sda_oe  <= 1'b1;
                     is_read <= rx_sh[0];
                     state   <= ST_ADDR_ACK;
                     if (rx_sh[0]) begin
                        reg_re  <= 1'b1;
                        ptr_inc <= 1'b1;
                     end
                  end else begin
                     state <= ST_IDLE;
                  end
               end
               ST_ADDR_ACK: begin
                  if (is_read) begin
                     tx_sh  <= rbuf;
                     sda_oe <= ~rbuf[7];
                     tcnt   <= '0;
                     state  <= ST_TX;
                  end else begin
                     sda_oe <= 1'b0;
                     bcnt   <= '0;
                     state  <= ST_PTR;
                  end
               end
               ST_PTR: if (bcnt == FULL) begin
                  ptr_load <= 1'b1;
                  ptr_din  <= rx_sh[PTR_W-1:0];
                  sda_oe   <= 1'b1;
                  state    <= ST_PTR_ACK;
               end
               ST_WR: if (bcnt == FULL) begin
                  reg_we    <= 1'b1;
                  reg_wdata <= rx_sh;
                  ptr_inc   <= 1'b1;
                  sda_oe    <= 1'b1;
                  state     <= ST_WR_ACK;
               end
               ST_PTR_ACK, ST_WR_ACK: begin
                  sda_oe <= 1'b0;
                  bcnt   <= '0;
                  state  <= ST_WR;
               end
               ST_TX: begin
                  if (tcnt == 3'd7) begin
                     sda_oe <= 1'b0;
                     state  <= ST_HOST_ACK;
                  end else begin
                     tx_sh  <= {tx_sh[6:0], 1'b0};
                     sda_oe <= ~tx_sh[6];
                     tcnt   <= tcnt + 1'b1;
                  end
               end
               ST_HOST_ACK: if (next_pend) begin
                  next_pend <= 1'b0;
                  tx_sh     <= rbuf;
                  sda_oe    <= ~rbuf[7];
                  tcnt      <= '0;
                  state     <= ST_TX;
               end
               default: ;
            endcase
         end else if (scl_up && state == ST_HOST_ACK && !next_pend) begin
            if (!sda_s) begin
               reg_re    <= 1'b1;
               ptr_inc   <= 1'b1;
               next_pend <= 1'b1;
            end else begin
               state <= ST_IDLE;
            end
         end
      end
   end

   // strobes are single-cycle and never coincide (R4, R5)
   assert_we_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);
   assert_re_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_re |=> !reg_re);
   assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_re));
   // the address seen with a strobe is followed by the next one (R9 wraps)
   assert_wr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> reg_addr == $past(reg_addr) + 1'b1);
   assert_rd_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_re |=> reg_addr == $past(reg_addr) + 1'b1);
   // SDA drive only moves while SCL is low, apart from bus conditions (R1)
   assert_sda_scl_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s || $past(bus_start || bus_stop));
   // an idle target never holds the line (R2)
   assert_idle_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_IDLE |-> !sda_oe);

endmodule

// File: tb/sim_i2c_regport.sv
module sim_i2c_regport;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_oe;
   logic [7:0] reg_addr, reg_wdata, reg_rdata;
   logic       reg_we, reg_re;
   logic       sda_bus;

   int unsigned total = 0;
   int unsigned fails = 0;
   int unsigned we_cnt = 0;
   int unsigned re_cnt = 0;
   logic [7:0]  mem [256];
   logic [7:0]  expv [256];

   always #2 clk = ~clk;

   assign sda_bus = sda_m & ~sda_oe;

   i2c_regport u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl),
      .sda_i    (sda_bus),
      .sda_oe   (sda_oe),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_we   (reg_we),
      .reg_re   (reg_re),
      .reg_rdata(reg_rdata)
   );

   // register file model
   always @(posedge clk) begin
      if (reg_we) begin
         mem[reg_addr] <= reg_wdata;
         we_cnt <= we_cnt + 1;
      end
      if (reg_re) begin
         reg_rdata <= mem[reg_addr];
         re_cnt <= re_cnt + 1;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic bit_out(input logic b);
      tick(4); sda_m = b; tick(4); scl = 1'b1; tick(8); scl = 1'b0;
   endtask

   task automatic bit_in(output logic b);
      tick(4); sda_m = 1'b1; tick(4); scl = 1'b1; tick(4); b = sda_bus; tick(4); scl = 1'b0;
   endtask

   task automatic bus_start();
      tick(2); sda_m = 1'b1; tick(4); scl = 1'b1; tick(4); sda_m = 1'b0; tick(4); scl = 1'b0;
   endtask

   task automatic bus_stop();
      tick(4); sda_m = 1'b0; tick(4); scl = 1'b1; tick(4); sda_m = 1'b1; tick(8);
   endtask

   task automatic send_byte(input logic [7:0] v, output logic acked);
      logic a;
      for (int i = 7; i >= 0; i--) bit_out(v[i]);
      bit_in(a);
      acked = ~a;
   endtask

   task automatic recv_byte(input logic nak, output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         bit_in(b);
         v[i] = b;
      end
      bit_out(nak);
   endtask

   localparam logic [7:0] AW = 8'h54;  // 0101010 + write
   localparam logic [7:0] AR = 8'h55;  // 0101010 + read

   initial begin
      repeat (190000) @(posedge clk);
      fails++; total++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  %0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      logic       ack;
      logic [7:0] v;
      int unsigned w0, r0;
      for (int i = 0; i < 256; i++) begin
         mem[i]  = 8'(i) ^ 8'hA5;
         expv[i] = 8'(i) ^ 8'hA5;
      end
      tick(5);
      #1;
      // R10 reset state
      check(sda_oe == 1'b0, "R10 sda released", sda_oe, 0);
      check(reg_we == 1'b0 && reg_re == 1'b0, "R10 strobes low", {reg_we, reg_re}, 0);
      check(reg_addr == 8'h00, "R10 pointer zero", reg_addr, 0);
      rst_n = 1'b1;
      tick(4);

      // R1 / R2 address sweep
      for (int a = 0; a < 128; a++) begin
         bus_start();
         send_byte({7'(a), 1'b0}, ack);
         bus_stop();
         check(ack == (a == 8'h2A), "R1 R2 address ack", ack, a == 8'h2A);
      end
      check(we_cnt == 0 && re_cnt == 0, "R2 no strobes on sweep", we_cnt + re_cnt, 0);

      // R2 bytes after a miss are ignored
      bus_start();
      send_byte(8'h56, ack);
      check(!ack, "R2 miss not acked", ack, 0);
      send_byte(8'h10, ack);
      check(!ack, "R2 trailing byte ignored", ack, 0);
      send_byte(8'h99, ack);
      check(!ack, "R2 trailing data ignored", ack, 0);
      bus_stop();
      check(we_cnt == 0 && mem[8'h10] == expv[8'h10], "R2 no write after miss", mem[8'h10], expv[8'h10]);

      // R3 / R4 burst write
      bus_start();
      send_byte(AW, ack);  check(ack, "R1 write address acked", ack, 1);
      send_byte(8'h10, ack); check(ack, "R3 pointer acked", ack, 1);
      for (int i = 0; i < 3; i++) begin
         send_byte(8'hC0 + 8'(i), ack);
         expv[8'h10 + i] = 8'hC0 + 8'(i);
         check(ack, "R4 data acked", ack, 1);
      end
      bus_stop();
      for (int i = 0; i < 3; i++)
         check(mem[8'h10 + i] == expv[8'h10 + i], "R4 burst written", mem[8'h10 + i], expv[8'h10 + i]);
      check(we_cnt == 3, "R4 write strobe count", we_cnt, 3);

      // R7 combined read, R6 NAK ends it
      r0 = re_cnt;
      bus_start();
      send_byte(AW, ack);
      send_byte(8'h11, ack);
      bus_start();
      send_byte(AR, ack); check(ack, "R1 read address acked", ack, 1);
      recv_byte(1'b0, v); check(v == expv[8'h11], "R7 first read at new pointer", v, expv[8'h11]);
      recv_byte(1'b1, v); check(v == expv[8'h12], "R5 next byte", v, expv[8'h12]);
      tick(8);
      check(sda_bus == 1'b1, "R6 released after NAK", sda_bus, 1);
      bus_stop();
      check(re_cnt - r0 == 2, "R6 no fetch after NAK", re_cnt - r0, 2);

      // R5 plain read continues from pointer
      bus_start();
      send_byte(AR, ack);
      recv_byte(1'b1, v);
      bus_stop();
      check(v == expv[8'h13], "R5 read from current pointer", v, expv[8'h13]);

      // R9 wrap on write, then read continues past wrap
      bus_start();
      send_byte(AW, ack);
      send_byte(8'hFE, ack);
      for (int i = 0; i < 4; i++) begin
         send_byte(8'h60 + 8'(i), ack);
         expv[8'(8'hFE + i)] = 8'h60 + 8'(i);
      end
      bus_stop();
      for (int i = 0; i < 4; i++)
         check(mem[8'(8'hFE + i)] == expv[8'(8'hFE + i)], "R9 write wraps", mem[8'(8'hFE + i)], expv[8'(8'hFE + i)]);
      bus_start();
      send_byte(AR, ack);
      recv_byte(1'b1, v);
      bus_stop();
      check(v == expv[8'h02], "R9 read after wrap", v, expv[8'h02]);

      // R8 stop in mid pointer byte
      w0 = we_cnt;
      bus_start();
      send_byte(AW, ack);
      bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
      bus_stop();
      bus_start();
      send_byte(AR, ack);
      recv_byte(1'b1, v);
      bus_stop();
      check(v == expv[8'h03], "R8 pointer kept after stop abort", v, expv[8'h03]);
      // R8 start in mid data byte
      bus_start();
      send_byte(AW, ack);
      send_byte(8'h20, ack);
      bit_out(1'b1); bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
      bus_start();
      send_byte(AW, ack);  check(ack, "R8 address after restart", ack, 1);
      send_byte(8'h30, ack);
      send_byte(8'h77, ack);
      expv[8'h30] = 8'h77;
      bus_stop();
      check(mem[8'h30] == 8'h77, "R8 write after restart", mem[8'h30], 8'h77);
      check(mem[8'h20] == expv[8'h20], "R8 aborted byte not written", mem[8'h20], expv[8'h20]);
      check(we_cnt - w0 == 1, "R8 single strobe", we_cnt - w0, 1);

      // full-space sweep: 256 writes from 0, then 256 reads from 0
      bus_start();
      send_byte(AW, ack);
      send_byte(8'h00, ack);
      for (int i = 0; i < 256; i++) begin
         send_byte(8'(i * 37 + 11), ack);
         expv[i] = 8'(i * 37 + 11);
      end
      bus_stop();
      check(reg_addr == 8'h00, "R9 pointer wrapped to zero", reg_addr, 0);
      bus_start();
      send_byte(AW, ack);
      send_byte(8'h00, ack);
      bus_start();
      send_byte(AR, ack);
      for (int i = 0; i < 256; i++) begin
         recv_byte(i == 255, v);
         check(v == expv[i], "R5 sweep readback", v, expv[i]);
      end
      bus_stop();
      check(reg_addr == 8'h00, "R9 read pointer wrapped", reg_addr, 0);

      $display("  %0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule